// File: doc/BRIEF.md
# Radio Transceiver Slot Sequencer

This block steers an external low-IF radio transceiver through one complete slot. On a start command it raises the regulator and transceiver power-up lines together. It waits a fixed time for the supplies to settle, then sends a channel word over a three-wire serial link. It waits again for the frequency synthesizer to lock, and finally holds either a receive slot or a transmit slot until a stop command arrives. All waits are counted in cycles of the block clock, which is also the reference clock that the block gates out to the radio.

The serial word is built from the command inputs when start is accepted. For transmit it holds the channel and the frequency deviation setting. For receive it holds the channel and a clock-recovery enable bit. When transmit is switched on, the data line first sends an alternating preamble and then passes the payload bit straight through. A stop command clears the transmit enable one cycle before both power-up lines fall.

Top module: `radio_slot_seq`

## Requirements
- R1: Out of reset, both power-up lines, the serial clock, the reference-clock gate, `tx_on` and `rx_slot` are low, and `ser_en` is high.
- R2: A `cmd_start` pulse in power-down raises `pu_reg` and `pu_trx` together in the next cycle. The reference-clock gate stays low during the supply wait that follows.
- R3: `ser_en` falls exactly PWR_CYC cycles after the power-up lines rise. PWR_CYC is ceil(PWR_SETTLE_NS * CLK_KHZ / 1e6).
- R4: While `ser_en` is low the link sends WORD_W bits, most significant bit first. Each bit is sampled on a rising `ser_clk` and stays stable while `ser_clk` is high. `ser_clk` toggles only while `ser_en` is low, each clock half lasts SCK_HALF cycles, and `ser_en` is low for (2*WORD_W+1)*SCK_HALF cycles.
- R5: For transmit, word bit WORD_W-1 is 1, bits CHAN_W-1..0 carry `chan_sel`, bits CHAN_W+DEV_W-1..CHAN_W carry `dev_sel`, and all other bits are 0.
- R6: For receive, word bit WORD_W-1 is 0, bits CHAN_W-1..0 carry `chan_sel`, bit CHAN_W carries `clk_rec_en`, and all other bits are 0. `dev_sel` has no effect on the word.
- R7: After `ser_en` rises, the slot selected by `cmd_tx` at start begins exactly PLL_CYC cycles later. PLL_CYC is ceil(PLL_SETTLE_NS * CLK_KHZ / 1e6). Only `tx_on` or only `rx_slot` goes high.
- R8: `ref_clk_en` is high throughout programming, the lock wait and both slots, and low otherwise.
- R9: From the first cycle of `tx_on`, `tx_data` sends PRE_BITS bits of 1,0,1,0,..., each lasting BIT_DIV cycles. After that it follows `tx_payload`.
- R10: `cmd_stop` in any state other than power-down drops `tx_on`, `rx_slot` and `ref_clk_en` in the next cycle while the power-up lines stay high. Both power-up lines fall one cycle later.
- R11: `cmd_start` has no effect unless the sequencer is in power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the reference clock passed to the radio |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start a slot cycle (one-cycle pulse) |
| cmd_tx | input | 1 | Direction at start: 1 transmit, 0 receive |
| cmd_stop | input | 1 | Return to power-down (one-cycle pulse) |
| chan_sel | input | CHAN_W | Channel number |
| dev_sel | input | DEV_W | Deviation setting (transmit only) |
| clk_rec_en | input | 1 | Clock-recovery enable (receive only) |
| tx_payload | input | 1 | Payload bit sent after the preamble |
| pu_reg | output | 1 | Regulator power-up line |
| pu_trx | output | 1 | Transceiver power-up line |
| ser_en | output | 1 | Serial enable, low during a transfer |
| ser_clk | output | 1 | Serial clock |
| ser_data | output | 1 | Serial data |
| ref_clk_en | output | 1 | Reference-clock gate |
| tx_on | output | 1 | Transmit enable |
| tx_data | output | 1 | Transmit data |
| rx_slot | output | 1 | Receive slot active |

## Verification
The hardest case to reach is a stop that arrives in the middle of the power-supply wait. No programming may follow it, and the sequence must restart cleanly from power-down. The stimulus issues a start, stops it a few cycles into the wait, and then runs a fresh receive cycle with a different word and a nonzero deviation input. The scoreboard then has to match that word exactly. The clock setting used by the bench makes both settling times fractional, so the round-up rule is checked at the exact cycle.

// File: rtl/radio_seq_pkg.sv
// Shared types for the slot sequencer.
package radio_seq_pkg;
    typedef enum logic [2:0] {
        ST_OFF,    // power-down, all lines idle
        ST_PWRUP,  // supplies settling
        ST_PROG,   // serial word transfer
        ST_LOCK,   // synthesizer settling
        ST_RX,     // receive slot
        ST_TX,     // transmit slot
        ST_DOWN    // transmit off, power lines still high
    } seq_state_t;
endpackage

// File: rtl/settle_timer.sv
// Counts cycles while run is high and flags the last cycle of a window of
// `limit` cycles. Assumes limit >= 1 and that run drops between windows.
module settle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Count up while running, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    // Last cycle of the window.
    assign done = run && (cnt == limit - 1'b1);
endmodule

// File: rtl/serial_prog.sv
// Three-wire word transfer. While go is high, enable is low. The word goes out
// MSB first; data changes while the clock is low and holds while it is high.
// The transfer is 2*WORD_W+1 half periods of SCK_HALF cycles, and done marks
// its final cycle. Assumes go stays high until done and the word is stable.
module serial_prog #(
    parameter int WORD_W   = 16,
    parameter int SCK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [WORD_W-1:0] word,
    output logic              ser_en,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              done
);
    localparam int H_LAST = 2 * WORD_W;
    localparam int HW     = $clog2(H_LAST + 1);
    localparam int SW     = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam int IDXW   = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [HW-1:0]   half_idx;
    logic [SW-1:0]   sub_cnt;
    logic            half_end;
    logic            last_half;
    logic [IDXW-1:0] bit_sel;

    assign half_end  = (sub_cnt == SW'(SCK_HALF - 1));
    assign last_half = (half_idx == HW'(H_LAST));

    // Step through clock half periods while a transfer is running.
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            half_idx <= '0;
            sub_cnt  <= '0;
        end else if (half_end) begin
            sub_cnt <= '0;
            if (!last_half) half_idx <= half_idx + 1'b1;
        end else begin
            sub_cnt <= sub_cnt + 1'b1;
        end
    end

    // Bit currently on the line: both halves of bit i use the same index.
    assign bit_sel  = IDXW'(WORD_W - 1) - IDXW'(half_idx[HW-1:1]);
    assign ser_en   = !go;
    assign ser_clk  = go && half_idx[0];
    assign ser_data = go && !last_half && word[bit_sel];
    assign done     = go && last_half && half_end;
endmodule

// File: rtl/tx_preamble.sv
// Transmit data source. On the first cycle of go it starts an alternating
// 1,0,1,0 preamble of PRE_BITS bits of BIT_DIV cycles each, then passes
// the payload through. The output is low while go is low.
module tx_preamble #(
    parameter int PRE_BITS = 8,
    parameter int BIT_DIV  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic payload,
    output logic tx_data
);
    localparam int BW = $clog2(PRE_BITS + 1);
    localparam int DW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1;

    logic [BW-1:0] bit_cnt;
    logic [DW-1:0] div_cnt;
    logic          in_pre;

    assign in_pre = (bit_cnt < BW'(PRE_BITS));

    // Time each preamble bit and count bits until the preamble ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !go) begin
            bit_cnt <= '0;
            div_cnt <= '0;
        end else if (in_pre) begin
            if (div_cnt == DW'(BIT_DIV - 1)) begin
                div_cnt <= '0;
                bit_cnt <= bit_cnt + 1'b1;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    // Even-numbered preamble bits are 1.
    assign tx_data = go && (in_pre ? !bit_cnt[0] : payload);
endmodule

// File: rtl/radio_slot_seq.sv
// Slot sequencer top. It powers the radio, waits for the supplies, programs the
// channel word, waits for the synthesizer, and then holds a receive or
// transmit slot until stopped. The block clock is the reference clock and all
// waits are counted in it. Assumes WORD_W >= CHAN_W + DEV_W + 1 and that
// start and stop are one-cycle pulses.
module radio_slot_seq
    import radio_seq_pkg::*;
#(
    parameter int CLK_KHZ       = 100_000,
    parameter int PWR_SETTLE_NS = 40_000,
    parameter int PLL_SETTLE_NS = 200_000,
    parameter int WORD_W        = 16,
    parameter int CHAN_W        = 7,
    parameter int DEV_W         = 3,
    parameter int SCK_HALF      = 2,
    parameter int PRE_BITS      = 8,
    parameter int BIT_DIV       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_tx,
    input  logic              cmd_stop,
    input  logic [CHAN_W-1:0] chan_sel,
    input  logic [DEV_W-1:0]  dev_sel,
    input  logic              clk_rec_en,
    input  logic              tx_payload,
    output logic              pu_reg,
    output logic              pu_trx,
    output logic              ser_en,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ref_clk_en,
    output logic              tx_on,
    output logic              tx_data,
    output logic              rx_slot
);
    localparam int PWR_CYC = int'((64'(PWR_SETTLE_NS) * 64'(CLK_KHZ) + 64'd999_999) / 64'd1_000_000);
    localparam int PLL_CYC = int'((64'(PLL_SETTLE_NS) * 64'(CLK_KHZ) + 64'd999_999) / 64'd1_000_000);
    localparam int MAX_CYC = (PWR_CYC > PLL_CYC) ? PWR_CYC : PLL_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_t        state, state_nx;
    logic              dir_tx;
    logic [WORD_W-1:0] word_q, word_nx;
    logic              timer_run, timer_done;
    logic [CNT_W-1:0]  timer_lim;
    logic              prog_done;

    // Build the serial word from the command inputs.
    always_comb begin
        word_nx             = '0;
        word_nx[CHAN_W-1:0] = chan_sel;
        word_nx[WORD_W-1]   = cmd_tx;
        if (cmd_tx) word_nx[CHAN_W+DEV_W-1:CHAN_W] = dev_sel;
        else        word_nx[CHAN_W]                = clk_rec_en;
    end

    // Capture direction and word when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_tx <= 1'b0;
            word_q <= '0;
        end else if (state == ST_OFF && cmd_start) begin
            dir_tx <= cmd_tx;
            word_q <= word_nx;
        end
    end

    // Next-state logic; stop has priority over every other event.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (cmd_start) state_nx = ST_PWRUP;
            ST_PWRUP: if (cmd_stop) state_nx = ST_DOWN;
                      else if (timer_done) state_nx = ST_PROG;
            ST_PROG:  if (cmd_stop) state_nx = ST_DOWN;
                      else if (prog_done) state_nx = ST_LOCK;
            ST_LOCK:  if (cmd_stop) state_nx = ST_DOWN;
                      else if (timer_done) state_nx = dir_tx ? ST_TX : ST_RX;
            ST_RX,
            ST_TX:    if (cmd_stop) state_nx = ST_DOWN;
            ST_DOWN:  state_nx = ST_OFF;
            default:  state_nx = ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // One timer serves both settling windows.
    assign timer_run = (state == ST_PWRUP) || (state == ST_LOCK);
    assign timer_lim = (state == ST_PWRUP) ? CNT_W'(PWR_CYC) : CNT_W'(PLL_CYC);

    settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .limit (timer_lim),
        .done  (timer_done)
    );

    serial_prog #(.WORD_W(WORD_W), .SCK_HALF(SCK_HALF)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (state == ST_PROG),
        .word     (word_q),
        .ser_en   (ser_en),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .done     (prog_done)
    );

    tx_preamble #(.PRE_BITS(PRE_BITS), .BIT_DIV(BIT_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (state == ST_TX),
        .payload (tx_payload),
        .tx_data (tx_data)
    );

    // Output decode from the state register.
    assign pu_reg     = (state != ST_OFF);
    assign pu_trx     = (state != ST_OFF);
    assign ref_clk_en = (state == ST_PROG) || (state == ST_LOCK) ||
                        (state == ST_RX)   || (state == ST_TX);
    assign tx_on      = (state == ST_TX);
    assign rx_slot    = (state == ST_RX);
endmodule

// File: rtl/radio_seq_checker.sv
// Port-level properties of the slot sequencer. Settling windows are checked
// with saturating counters, not deep $past chains. Bound to radio_slot_seq.
module radio_seq_checker #(
    parameter int PWR_CYC = 1,
    parameter int PLL_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_stop,
    input logic pu_reg,
    input logic ser_en,
    input logic ser_clk,
    input logic ser_data,
    input logic ref_clk_en,
    input logic tx_on,
    input logic tx_data,
    input logic rx_slot
);
    int unsigned pu_age, lock_age;

    // Cycles since power-up, and cycles since the enable last went high.
    always_ff @(posedge clk) begin
        if (!rst_n || !pu_reg) pu_age <= 0;
        else if (pu_age < 32'hFFFF_FFF0) pu_age <= pu_age + 1;
        if (!rst_n || !pu_reg || !ser_en) lock_age <= 0;
        else if (lock_age < 32'hFFFF_FFF0) lock_age <= lock_age + 1;
    end

    p_pu_rise_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pu_reg) |-> (ser_en && !ref_clk_en));
    p_pwr_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_en) |-> (pu_age >= PWR_CYC));
    p_clk_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> !ser_en);
    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
    p_lock_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_on) || $rose(rx_slot)) |-> (lock_age >= PLL_CYC));
    p_refclk_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en || tx_on || rx_slot) |-> ref_clk_en);
    p_preamble_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_on) |-> tx_data);
    p_stop_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pu_reg) |-> ($past(!tx_on) && !ref_clk_en));
    p_slot_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rx_slot) && !$past(cmd_stop)) |-> rx_slot);
endmodule

bind radio_slot_seq radio_seq_checker #(.PWR_CYC(PWR_CYC), .PLL_CYC(PLL_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_stop   (cmd_stop),
    .pu_reg     (pu_reg),
    .ser_en     (ser_en),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .ref_clk_en (ref_clk_en),
    .tx_on      (tx_on),
    .tx_data    (tx_data),
    .rx_slot    (rx_slot)
);

// File: tb/tb_radio_slot_seq.sv
// Scoreboard bench: the driver queues expected serial words and the monitor
// rebuilds each transferred word from the pins and compares it.
module tb_radio_slot_seq;
    localparam int CLK_KHZ  = 10_001;   // makes both waits fractional
    localparam int W        = 16;
    localparam int CW       = 7;
    localparam int DW       = 3;
    localparam int HALF     = 2;
    localparam int PRE      = 8;
    localparam int DIV      = 3;
    localparam int EXP_PWR  = 401;      // ceil(40000*10001/1e6)
    localparam int EXP_PLL  = 2001;     // ceil(200000*10001/1e6)
    localparam int EXP_FRM  = (2 * W + 1) * HALF;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, cmd_tx = 1'b0, cmd_stop = 1'b0;
    logic [CW-1:0] chan_sel = '0;
    logic [DW-1:0] dev_sel = '0;
    logic clk_rec_en = 1'b0, tx_payload = 1'b0;
    logic pu_reg, pu_trx, ser_en, ser_clk, ser_data, ref_clk_en, tx_on, tx_data, rx_slot;

    radio_slot_seq #(
        .CLK_KHZ(CLK_KHZ), .WORD_W(W), .CHAN_W(CW), .DEV_W(DW),
        .SCK_HALF(HALF), .PRE_BITS(PRE), .BIT_DIV(DIV)
    ) dut (.*);

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [W-1:0] exp_q[$];
    string        tag_q[$];

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected word per R5/R6.
    function automatic logic [W-1:0] exp_word(bit tx, int ch, int dv, bit cr);
        logic [W-1:0] w = '0;
        w[CW-1:0] = CW'(ch);
        w[W-1] = tx;
        if (tx) w[CW+DW-1:CW] = DW'(dv);
        else    w[CW] = cr;
        return w;
    endfunction

    // Monitor: rebuild each word from rising serial clocks, compare on enable rise.
    logic prev_sclk = 1'b0, prev_en = 1'b1;
    logic [W-1:0] shreg = '0;
    int nbits = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ser_en && prev_en) begin shreg = '0; nbits = 0; end
            if (ser_clk && !prev_sclk) begin shreg = {shreg[W-2:0], ser_data}; nbits++; end
            if (ser_en && !prev_en) begin
                check("R4 bit count", nbits, W);
                if (exp_q.size() == 0) check("R4 unexpected word", 1, 0);
                else begin
                    string t = tag_q.pop_front();
                    check(t, int'(shreg), int'(exp_q.pop_front()));
                end
            end
        end
        prev_sclk = ser_clk;
        prev_en   = ser_en;
    end

    task automatic start_cmd(bit tx, int ch, int dv, bit cr, bit expect_word);
        cmd_tx = tx; chan_sel = CW'(ch); dev_sel = DW'(dv); clk_rec_en = cr;
        if (expect_word) begin
            exp_q.push_back(exp_word(tx, ch, dv, cr));
            tag_q.push_back(tx ? "R5 tx word" : "R6 rx word");
        end
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    // Follow one cycle from power-up to slot entry and time each phase.
    task automatic run_to_slot(bit tx);
        int n, refbad;
        check("R2 pu_reg", pu_reg, 1);
        check("R2 pu_trx", pu_trx, 1);
        check("R2 refclk off", ref_clk_en, 0);
        n = 0;
        while (ser_en && n < 10000) begin @(negedge clk); n++; end
        check("R3 power wait", n, EXP_PWR);
        n = 0; refbad = 0;
        while (!ser_en && n < 10000) begin
            if (!ref_clk_en) refbad++;
            @(negedge clk); n++;
        end
        check("R4 enable low length", n, EXP_FRM);
        check("R8 refclk in programming", refbad, 0);
        n = 0; refbad = 0;
        while (!(tx ? tx_on : rx_slot) && n < 10000) begin
            if (!ref_clk_en) refbad++;
            @(negedge clk); n++;
        end
        check("R7 lock wait", n, EXP_PLL);
        check("R8 refclk in lock wait", refbad, 0);
        check("R7 other slot low", tx ? rx_slot : tx_on, 0);
        check("R8 refclk in slot", ref_clk_en, 1);
    endtask

    task automatic stop_cmd();
        cmd_stop = 1'b1;
        @(negedge clk);
        cmd_stop = 1'b0;
        check("R10 tx_on off first", tx_on, 0);
        check("R10 rx_slot off", rx_slot, 0);
        check("R10 pu held one cycle", pu_reg, 1);
        check("R10 refclk off", ref_clk_en, 0);
        @(negedge clk);
        check("R10 pu_reg off", pu_reg, 0);
        check("R10 pu_trx off", pu_trx, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check("R1 pu_reg", pu_reg, 0);
        check("R1 pu_trx", pu_trx, 0);
        check("R1 ser_en", ser_en, 1);
        check("R1 ser_clk", ser_clk, 0);
        check("R1 ref_clk_en", ref_clk_en, 0);
        check("R1 tx_on", tx_on, 0);
        check("R1 rx_slot", rx_slot, 0);

        // Receive slot with clock recovery and a nonzero deviation input.
        start_cmd(1'b0, 'h2A, 5, 1'b1, 1'b1);
        run_to_slot(1'b0);
        // R11: start during a slot is ignored.
        cmd_tx = 1'b1; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (5) @(negedge clk);
        check("R11 still rx", rx_slot, 1);
        check("R11 no tx", tx_on, 0);
        check("R11 no reprogram", ser_en, 1);
        stop_cmd();

        // Transmit slot: preamble and then payload.
        tx_payload = 1'b0;
        start_cmd(1'b1, 'h13, 5, 1'b1, 1'b1);
        run_to_slot(1'b1);
        for (int i = 0; i < PRE * DIV; i++) begin
            check("R9 preamble", tx_data, ((i / DIV) % 2 == 0) ? 1 : 0);
            @(negedge clk);
        end
        check("R9 payload 0", tx_data, 0);
        tx_payload = 1'b1;
        @(negedge clk);
        check("R9 payload 1", tx_data, 1);
        stop_cmd();

        // Stop during the supply wait: no transfer may follow.
        start_cmd(1'b0, 'h11, 0, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        stop_cmd();
        begin
            int lows = 0;
            for (int i = 0; i < EXP_PWR + 20; i++) begin
                if (!ser_en || pu_reg) lows++;
                @(negedge clk);
            end
            check("R10 abort stays off", lows, 0);
        end

        // Fresh receive cycle, no clock recovery, deviation input set (R6).
        start_cmd(1'b0, 'h7F, 7, 1'b0, 1'b1);
        run_to_slot(1'b0);
        stop_cmd();

        repeat (3) @(negedge clk);
        check("R4 all words seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule